// File: doc/BRIEF.md
# Shared-Temp Wide Register Bridge

This block lets an 8-bit processor bus read and write a bank of 10-bit timer registers without tearing. The bank holds a counter in slot 0 and compare values in the other slots. Each wide register has one bus address for its low byte. One extra address reaches a single 2-bit staging register, and every wide register shares it as the holder of the upper bits.

To write a wide value, software first puts the upper bits into the staging register. It then writes the low byte. That low-byte write loads all ten bits into the target register on one clock edge. The staging value stays in place, so a run of registers that share the same upper bits needs only one staging write. To read a wide value, software reads the low byte first. On that same edge the register's upper bits are latched into the staging register, and a second read of the staging address returns them. A hardware port can load the counter directly. A processor write to the counter in the same cycle takes precedence over that load.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset every 10-bit register and the staging register hold zero.
- R2: A write to the staging address (address NREG, 5 by default) changes only the staging value, to write data bits 1:0. A read of that address returns the staging value in bits 1:0 and zeros in bits 7:2.
- R3: A write to low-byte address k (0 = counter, 1..NREG-1 = compares) loads register k with {staging, write data} on that clock edge.
- R4: A low-byte write changes no register other than the one addressed.
- R5: A low-byte write leaves the staging value unchanged, so a single staging write serves several later low-byte writes.
- R6: While low-byte address k is presented, read data equals bits 7:0 of register k. A read strobe at that address copies bits 9:8 of register k into the staging register on that edge.
- R7: A hardware load with no processor counter write sets the counter to the hardware value. If both occur in the same cycle, the processor value wins. The hardware load never changes the compares or the staging register.
- R8: Addresses above NREG are unmapped. They read as zero, and a write to them changes neither any register nor the staging value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, combinational from address |
| hw_cnt_load | input | 1 | Hardware counter load enable |
| hw_cnt_val | input | 10 | Hardware counter load value |
| regs_q | output | 50 | All 10-bit registers packed, slot k at bits 10k+9:10k |

## Verification
Every register update, including the staging capture on a low-byte read, takes effect on the rising edge where the strobe is sampled. The result is therefore visible one cycle after the strobe is driven. Read data follows the address with no register stage, so the bench samples it 1 ns after driving the address, within the same cycle. The bench drives all stimulus on falling edges and checks registers and the staging readback on the next falling edge, after exactly one rising edge has passed. A model kept in the bench tracks every register, and after each operation the whole bank is compared against it, so side effects on registers that were not addressed are also caught.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_LOW  = 2'd1,
    ACC_TEMP = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode #(
  parameter int NREG   = 5,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  output wrb_pkg::acc_kind_e kind,
  output logic [NREG-1:0]    low_sel,
  output logic [NREG-1:0]    wr_low,
  output logic [NREG-1:0]    rd_low,
  output logic               wr_temp,
  output logic               unmapped_rd,
  output logic               unmapped_wr
);
  localparam logic [ADDR_W-1:0] TEMP_ADDR = ADDR_W'(NREG);

  logic temp_sel;
  logic unmapped;

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign low_sel[k] = (addr == ADDR_W'(k));
    assign wr_low[k]  = wr & low_sel[k];
    assign rd_low[k]  = rd & low_sel[k];
  end

  assign temp_sel    = (addr == TEMP_ADDR);
  assign unmapped    = ~temp_sel & ~(|low_sel);
  assign wr_temp     = wr & temp_sel;
  assign unmapped_rd = rd & unmapped;
  assign unmapped_wr = wr & unmapped;

  always_comb begin
    if (temp_sel)      kind = wrb_pkg::ACC_TEMP;
    else if (unmapped) kind = wrb_pkg::ACC_NONE;
    else               kind = wrb_pkg::ACC_LOW;
  end
endmodule

// File: rtl/wrb_temp.sv
module wrb_temp #(
  parameter int HI_W  = 2,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_temp,
  input  logic [BUS_W-1:0] wdata,
  input  logic             cap_en,
  input  logic [HI_W-1:0]  cap_val,
  output logic [HI_W-1:0]  tmp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmp_q <= '0;
    else if (wr_temp) tmp_q <= wdata[HI_W-1:0];
    else if (cap_en)  tmp_q <= cap_val;
  end
endmodule

// File: rtl/wrb_regfile.sv
module wrb_regfile #(
  parameter int NREG  = 5,
  parameter int REG_W = 10,
  parameter int BUS_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREG-1:0]       wr_low,
  input  logic [BUS_W-1:0]      wdata,
  input  logic [REG_W-BUS_W-1:0] tmp,
  input  logic                  hw_load,
  input  logic [REG_W-1:0]      hw_val,
  output logic [NREG*REG_W-1:0] q_flat
);
  localparam int HI_W = REG_W - BUS_W;

  function automatic logic [REG_W-1:0] join_hl(input logic [HI_W-1:0] h,
                                               input logic [BUS_W-1:0] l);
    return {h, l};
  endfunction

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [REG_W-1:0] r;
    if (k == 0) begin : g_cnt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         r <= '0;
        else if (wr_low[k]) r <= join_hl(tmp, wdata);
        else if (hw_load)   r <= hw_val;
      end
    end else begin : g_cmp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         r <= '0;
        else if (wr_low[k]) r <= join_hl(tmp, wdata);
      end
    end
    assign q_flat[k*REG_W +: REG_W] = r;
  end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int NREG   = 5,
  parameter int REG_W  = 10,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic                  hw_cnt_load,
  input  logic [REG_W-1:0]      hw_cnt_val,
  output logic [NREG*REG_W-1:0] regs_q
);
  localparam int HI_W = REG_W - BUS_W;

  wrb_pkg::acc_kind_e kind;
  logic [NREG-1:0] low_sel;
  logic [NREG-1:0] wr_low_ev;
  logic [NREG-1:0] rd_low_ev;
  logic            wr_temp_ev;
  logic            unmapped_rd_ev;
  logic            unmapped_wr_ev;
  logic            cap_en;
  logic [HI_W-1:0] cap_hi;
  logic [HI_W-1:0] tmp_q;

  wrb_decode #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .kind(kind),
    .low_sel(low_sel), .wr_low(wr_low_ev), .rd_low(rd_low_ev),
    .wr_temp(wr_temp_ev), .unmapped_rd(unmapped_rd_ev),
    .unmapped_wr(unmapped_wr_ev)
  );

  always_comb begin
    cap_hi = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_low_ev[k]) cap_hi = regs_q[k*REG_W+BUS_W +: HI_W];
  end
  assign cap_en = |rd_low_ev;

  wrb_temp #(.HI_W(HI_W), .BUS_W(BUS_W)) u_tmp (
    .clk(clk), .rst_n(rst_n), .wr_temp(wr_temp_ev), .wdata(bus_wdata),
    .cap_en(cap_en), .cap_val(cap_hi), .tmp_q(tmp_q)
  );

  wrb_regfile #(.NREG(NREG), .REG_W(REG_W), .BUS_W(BUS_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_low(wr_low_ev), .wdata(bus_wdata),
    .tmp(tmp_q), .hw_load(hw_cnt_load), .hw_val(hw_cnt_val), .q_flat(regs_q)
  );

  always_comb begin
    bus_rdata = '0;
    case (kind)
      wrb_pkg::ACC_TEMP: bus_rdata = BUS_W'(tmp_q);
      wrb_pkg::ACC_LOW: begin
        for (int k = 0; k < NREG; k++)
          if (low_sel[k]) bus_rdata = regs_q[k*REG_W +: BUS_W];
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int NREG  = 5,
  parameter int REG_W = 10,
  parameter int BUS_W = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [BUS_W-1:0]          bus_wdata,
  input logic [BUS_W-1:0]          bus_rdata,
  input logic [NREG-1:0]           wr_low_ev,
  input logic [NREG-1:0]           rd_low_ev,
  input logic                      wr_temp_ev,
  input logic                      unmapped_rd_ev,
  input logic                      unmapped_wr_ev,
  input logic                      hw_cnt_load,
  input logic [REG_W-1:0]          hw_cnt_val,
  input logic [REG_W-BUS_W-1:0]    tmp_q,
  input logic [NREG*REG_W-1:0]     regs_q
);
  localparam int HI_W = REG_W - BUS_W;

  p_temp_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_temp_ev |=> tmp_q == $past(bus_wdata[HI_W-1:0]));

  p_temp_write_regs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_temp_ev && !hw_cnt_load) |=> $stable(regs_q));

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    p_low_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_low_ev[k] |=> regs_q[k*REG_W +: REG_W] == {$past(tmp_q), $past(bus_wdata)});

    p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_low_ev[k] && !wr_temp_ev) |=> tmp_q == $past(regs_q[k*REG_W+BUS_W +: HI_W]));
  end

  p_temp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_low_ev) && !(|rd_low_ev) && !wr_temp_ev) |=> $stable(tmp_q));

  p_hw_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_cnt_load && !wr_low_ev[0]) |=> regs_q[REG_W-1:0] == $past(hw_cnt_val));

  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd_ev |-> bus_rdata == '0);

  p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unmapped_wr_ev && !hw_cnt_load && !(|rd_low_ev)) |=> ($stable(regs_q) && $stable(tmp_q)));
endmodule

bind wide_reg_bridge wrb_checker #(.NREG(NREG), .REG_W(REG_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .wr_low_ev(wr_low_ev), .rd_low_ev(rd_low_ev), .wr_temp_ev(wr_temp_ev),
  .unmapped_rd_ev(unmapped_rd_ev), .unmapped_wr_ev(unmapped_wr_ev),
  .hw_cnt_load(hw_cnt_load), .hw_cnt_val(hw_cnt_val), .tmp_q(tmp_q), .regs_q(regs_q)
);

// File: tb/wide_reg_bridge_test.sv
module wide_reg_bridge_test;
  localparam int NREG = 5;
  localparam int RW = 10;
  localparam int TEMP_A = NREG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        hw_cnt_load = 1'b0;
  logic [9:0]  hw_cnt_val = '0;
  logic [NREG*RW-1:0] regs_q;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q [NREG];
  logic [1:0] exp_tmp;
  logic [7:0] rv;

  always #5 clk = ~clk;

  wide_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_cnt_load(hw_cnt_load), .hw_cnt_val(hw_cnt_val), .regs_q(regs_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_bus(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_bus(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // compares every register and the staging readback to the model
  task automatic check_bank(input string req);
    logic [7:0] t;
    for (int k = 0; k < NREG; k++)
      chk(req, 32'(regs_q[k*RW +: RW]), 32'(exp_q[k]));
    rd_bus(4'(TEMP_A), t);
    chk(req, 32'(t), {30'd0, exp_tmp});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) exp_q[k] = '0;
    exp_tmp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_bank("R1");

    // R2: staging writes across all values, upper write bits ignored
    for (int h = 0; h < 4; h++) begin
      wr_bus(4'(TEMP_A), 8'hFC | 8'(h));
      exp_tmp = 2'(h);
      check_bank("R2");
    end

    // R3/R4: every register, every upper value, several low bytes
    for (int h = 0; h < 4; h++) begin
      wr_bus(4'(TEMP_A), 8'(h));
      exp_tmp = 2'(h);
      for (int k = 0; k < NREG; k++) begin
        for (int p = 0; p < 4; p++) begin
          logic [7:0] lo;
          lo = 8'((p * 8'h55) ^ (k * 8'h13) ^ (h * 8'h29));
          wr_bus(4'(k), lo);
          exp_q[k] = {2'(h), lo};
          for (int j = 0; j < NREG; j++)
            chk(j == k ? "R3" : "R4", 32'(regs_q[j*RW +: RW]), 32'(exp_q[j]));
        end
      end
    end

    // R5: one staging write reused by all low-byte writes
    wr_bus(4'(TEMP_A), 8'h02);
    exp_tmp = 2'd2;
    for (int k = 0; k < NREG; k++) begin
      wr_bus(4'(k), 8'(8'h10 + k));
      exp_q[k] = {2'd2, 8'(8'h10 + k)};
    end
    check_bank("R5");

    // R6: low-byte read returns low bits and captures upper bits
    for (int k = 0; k < NREG; k++) begin
      wr_bus(4'(TEMP_A), 8'(k + 1));
      wr_bus(4'(k), 8'(8'hA0 + k));
      exp_q[k] = {2'(k + 1), 8'(8'hA0 + k)};
      wr_bus(4'(TEMP_A), 8'(~(k + 1)));
      rd_bus(4'(k), rv);
      chk("R6", 32'(rv), 32'(exp_q[k][7:0]));
      exp_tmp = exp_q[k][9:8];
      rd_bus(4'(TEMP_A), rv);
      chk("R6", 32'(rv), {30'd0, exp_tmp});
    end

    // R7: hardware load alone
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      hw_cnt_load = 1'b1; hw_cnt_val = 10'(v * 10'h111 + 10'h0C3);
      @(negedge clk);
      hw_cnt_load = 1'b0;
      exp_q[0] = 10'(v * 10'h111 + 10'h0C3);
      check_bank("R7");
    end
    // R7: simultaneous processor write wins
    wr_bus(4'(TEMP_A), 8'h01);
    exp_tmp = 2'd1;
    @(negedge clk);
    hw_cnt_load = 1'b1; hw_cnt_val = 10'h3FF;
    bus_addr = 4'd0; bus_wdata = 8'h5A; bus_wr = 1'b1;
    @(negedge clk);
    hw_cnt_load = 1'b0; bus_wr = 1'b0;
    exp_q[0] = {2'd1, 8'h5A};
    check_bank("R7");
    // R7: hardware load while a compare is written: both take effect
    @(negedge clk);
    hw_cnt_load = 1'b1; hw_cnt_val = 10'h2B7;
    bus_addr = 4'd3; bus_wdata = 8'h77; bus_wr = 1'b1;
    @(negedge clk);
    hw_cnt_load = 1'b0; bus_wr = 1'b0;
    exp_q[0] = 10'h2B7;
    exp_q[3] = {2'd1, 8'h77};
    check_bank("R7");

    // R8: unmapped addresses
    for (int a = NREG + 1; a < 16; a++) begin
      wr_bus(4'(a), 8'hFF);
      rd_bus(4'(a), rv);
      chk("R8", 32'(rv), 32'd0);
      check_bank("R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule